// File: doc/BRIEF.md
# Core Memory Cycle Controller

This block sequences access cycles for a coincident-current magnetic core store of 8192 words of 18 bits. A request carries an address, a cycle mode and two byte-lane enables. The block decodes the address into one X drive line and one Y drive line. It then steps through a sense phase and a store phase. In the store phase the block either puts back the word it has just destroyed by reading it, or replaces the lanes being written.

The request side is a valid/ready handshake. `req_ready` is high only while the controller is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a cycle is running, `req_ready` stays low, and the requester must hold its request until it is accepted. The response has no back-pressure: `rsp_data` is valid during the single `done` cycle. A behavioural core plane array inside the block holds the stored state. Its read clears the addressed core in every plane.

Top module: `core_cycle_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no cycle is running. A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and `busy` is high from the next cycle on.
- R2: While `drive_en` is high, exactly one bit of `x_drive` is set, at index `req_addr[12:6]`. Exactly one bit of `y_drive` is set, at index `req_addr[5:0]`. When `drive_en` is low, both vectors are zero.
- R3: When a request is accepted at edge k, cycle k+1 is the sense phase (`drive_en` and `sense_strobe` high). Cycle k+2 is the store phase (`drive_en` high, `sense_strobe` low). Cycle k+3 is a single `done` cycle, and `req_ready` returns in cycle k+4.
- R4: A read/restore cycle (`req_mode`=0) returns the stored word on `rsp_data` during `done`. The word is written back, so a second read returns it again.
- R5: A clear/write cycle (`req_mode`=1) with `req_be`=2'b11 stores `req_wdata`, and a later read returns it.
- R6: Lane 0 is bits [8:0], enabled by `req_be[0]`. Lane 1 is bits [17:9], enabled by `req_be[1]`. In clear/write, a lane whose enable is low keeps its old contents. In read/restore, the enables have no effect on what is restored.
- R7: `inhibit[b]` is high only in the store phase, and only when bit b of the word to be stored is zero.
- R8: In both modes, `rsp_data` during `done` is the word the location held before the cycle.
- R9: A request presented while a cycle is running is ignored and does not change the running cycle.
- R10: After reset the controller is idle: `req_ready` high, and `busy`, `done`, `drive_en`, `sense_strobe` and `inhibit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_mode | input | 1 | 0 = read/restore, 1 = clear/write |
| req_addr | input | 13 | Word address (X = [12:6], Y = [5:0]) |
| req_be | input | 2 | Byte-lane enables |
| req_wdata | input | 18 | Write data |
| rsp_data | output | 18 | Word sensed in this cycle, valid with done |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| x_drive | output | 128 | One-hot X line drive select |
| y_drive | output | 64 | One-hot Y line drive select |
| drive_en | output | 1 | Read or store drive current on |
| sense_strobe | output | 1 | Sense gating and data latch strobe |
| inhibit | output | 18 | Per-plane inhibit drive |

## Verification
Take edge k as the rising edge that accepts a request. The drive selects and the sense strobe are due in cycle k+1. Inhibit is due in cycle k+2, and `done` with `rsp_data` is due in cycle k+3. `req_ready` comes back in cycle k+4. A behavioural model in the bench advances its phase counter on each rising edge from the same inputs the design sees. On each falling edge, every output is compared with what the model expects for that phase. The model keeps its own copy of the memory contents, so both the returned word and the stored word can be checked.

// File: rtl/core_cyc_pkg.sv
package core_cyc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SENSE = 2'd1,
    PH_STORE = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  typedef enum logic {
    MODE_READ_RESTORE = 1'b0,
    MODE_CLEAR_WRITE  = 1'b1
  } cyc_mode_e;
endpackage

// File: rtl/core_addr_decode.sv
module core_addr_decode #(
  parameter int X_BITS = 7,
  parameter int Y_BITS = 6,
  localparam int AW = X_BITS + Y_BITS,
  localparam int XN = 1 << X_BITS,
  localparam int YN = 1 << Y_BITS
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [XN-1:0] x_sel,
  output logic [YN-1:0] y_sel
);
  logic [X_BITS-1:0] x_idx;
  logic [Y_BITS-1:0] y_idx;
  assign x_idx = addr[AW-1:Y_BITS];
  assign y_idx = addr[Y_BITS-1:0];

  for (genvar gx = 0; gx < XN; gx++) begin : g_x
    assign x_sel[gx] = en && (x_idx == X_BITS'(gx));
  end
  for (genvar gy = 0; gy < YN; gy++) begin : g_y
    assign y_sel[gy] = en && (y_idx == Y_BITS'(gy));
  end
endmodule

// File: rtl/core_plane_array.sv
module core_plane_array #(
  parameter int X_BITS = 7,
  parameter int Y_BITS = 6,
  parameter int WORD_W = 18,
  localparam int AW = X_BITS + Y_BITS,
  localparam int XN = 1 << X_BITS,
  localparam int YN = 1 << Y_BITS,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic [XN-1:0]     x_sel,
  input  logic [YN-1:0]     y_sel,
  input  logic              drive_en,
  input  logic              sense_gate,
  input  logic [WORD_W-1:0] inhibit,
  output logic [WORD_W-1:0] sense_word
);
  logic [WORD_W-1:0] cores [DEPTH];
  logic [X_BITS-1:0] xi;
  logic [Y_BITS-1:0] yi;
  logic [AW-1:0]     idx;

  always_comb begin
    xi = '0;
    for (int i = 0; i < XN; i++) if (x_sel[i]) xi = i[X_BITS-1:0];
    yi = '0;
    for (int j = 0; j < YN; j++) if (y_sel[j]) yi = j[Y_BITS-1:0];
  end
  assign idx = {xi, yi};

  assign sense_word = sense_gate ? cores[idx] : '0;

  // Reading switches every addressed core to zero; storing switches
  // to one each core whose plane is not inhibited.
  always_ff @(posedge clk) begin
    if (drive_en) begin
      if (sense_gate) cores[idx] <= '0;
      else            cores[idx] <= cores[idx] | ~inhibit;
    end
  end
endmodule

// File: rtl/core_seq.sv
module core_seq
  import core_cyc_pkg::*;
#(
  parameter int AW     = 13,
  parameter int WORD_W = 18,
  parameter int LANES  = 2,
  localparam int LW = WORD_W / LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] sense_word,
  output logic [AW-1:0]     cur_addr,
  output logic [WORD_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic              drive_en,
  output logic              sense_strobe,
  output logic [WORD_W-1:0] inhibit
);
  phase_e            phase;
  cyc_mode_e         mode_q;
  logic [AW-1:0]     addr_q;
  logic [LANES-1:0]  be_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      mode_q  <= MODE_READ_RESTORE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          mode_q  <= cyc_mode_e'(req_mode);
          addr_q  <= req_addr;
          be_q    <= req_be;
          wdata_q <= req_wdata;
          phase   <= PH_SENSE;
        end
        PH_SENSE: begin
          data_q <= sense_word;
          phase  <= PH_STORE;
        end
        PH_STORE: phase <= PH_DONE;
        PH_DONE:  phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_wr;
    assign lane_wr = (mode_q == MODE_CLEAR_WRITE) && be_q[l];
    assign target[l*LW +: LW] = lane_wr ? wdata_q[l*LW +: LW] : data_q[l*LW +: LW];
  end

  assign req_ready    = (phase == PH_IDLE);
  assign busy         = (phase != PH_IDLE);
  assign done         = (phase == PH_DONE);
  assign drive_en     = (phase == PH_SENSE) || (phase == PH_STORE);
  assign sense_strobe = (phase == PH_SENSE);
  assign inhibit      = (phase == PH_STORE) ? ~target : '0;
  assign cur_addr     = addr_q;
  assign rsp_data     = data_q;

  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && sense_strobe));
  p_sense_then_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |=> (drive_en && !sense_strobe));
  p_store_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !sense_strobe) |=> done);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cur_addr));
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl #(
  parameter int X_BITS = 7,
  parameter int Y_BITS = 6,
  parameter int WORD_W = 18,
  parameter int LANES  = 2,
  localparam int AW = X_BITS + Y_BITS,
  localparam int XN = 1 << X_BITS,
  localparam int YN = 1 << Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic [XN-1:0]     x_drive,
  output logic [YN-1:0]     y_drive,
  output logic              drive_en,
  output logic              sense_strobe,
  output logic [WORD_W-1:0] inhibit
);
  logic [AW-1:0]     cur_addr;
  logic [WORD_W-1:0] sense_word;

  core_seq #(.AW(AW), .WORD_W(WORD_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .sense_word(sense_word), .cur_addr(cur_addr), .rsp_data(rsp_data),
    .busy(busy), .done(done), .drive_en(drive_en),
    .sense_strobe(sense_strobe), .inhibit(inhibit)
  );

  core_addr_decode #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_dec (
    .en(drive_en), .addr(cur_addr), .x_sel(x_drive), .y_sel(y_drive)
  );

  core_plane_array #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .WORD_W(WORD_W)) u_array (
    .clk(clk), .x_sel(x_drive), .y_sel(y_drive), .drive_en(drive_en),
    .sense_gate(sense_strobe), .inhibit(inhibit), .sense_word(sense_word)
  );

  p_onehot_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> ($onehot(x_drive) && $onehot(y_drive)));
  p_quiet_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (x_drive == '0 && y_drive == '0));
  p_inhibit_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != '0) |-> (drive_en && !sense_strobe));
endmodule

// File: tb/core_cycle_ctrl_tb.sv
module core_cycle_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_mode = 1'b0;
  logic [12:0]  req_addr = '0;
  logic [1:0]   req_be = '0;
  logic [17:0]  req_wdata = '0;
  logic [17:0]  rsp_data;
  logic         busy, done, drive_en, sense_strobe;
  logic [127:0] x_drive;
  logic [63:0]  y_drive;
  logic [17:0]  inhibit;

  core_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_data(rsp_data), .busy(busy), .done(done),
    .x_drive(x_drive), .y_drive(y_drive), .drive_en(drive_en),
    .sense_strobe(sense_strobe), .inhibit(inhibit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_tag = "R4";

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference
  int          ph = 0;
  logic [12:0] m_addr;
  logic        m_mode;
  logic [1:0]  m_be;
  logic [17:0] m_wd;
  logic [17:0] m_sensed;
  bit          m_known;
  bit [17:0]   refmem [int];

  function automatic logic [17:0] m_target();
    logic [17:0] t;
    t = m_sensed;
    if (m_mode && m_be[0]) t[8:0]  = m_wd[8:0];
    if (m_mode && m_be[1]) t[17:9] = m_wd[17:9];
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else begin
      case (ph)
        0: if (req_valid) begin
          m_addr = req_addr; m_mode = req_mode; m_be = req_be; m_wd = req_wdata;
          ph = 1;
        end
        1: begin
          m_known  = refmem.exists(int'(m_addr));
          m_sensed = m_known ? refmem[int'(m_addr)] : '0;
          ph = 2;
        end
        2: begin
          if (m_known || (m_mode && m_be == 2'b11)) refmem[int'(m_addr)] = m_target();
          ph = 3;
        end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic drv;
      drv = (ph == 1) || (ph == 2);
      chk((ph == 0) ? "R1" : "R9", {127'b0, req_ready}, {127'b0, ph == 0});
      chk("R1", {127'b0, busy}, {127'b0, ph != 0});
      chk("R3", {127'b0, done}, {127'b0, ph == 3});
      chk("R3", {127'b0, drive_en}, {127'b0, drv});
      chk("R3", {127'b0, sense_strobe}, {127'b0, ph == 1});
      chk("R2", x_drive, drv ? (128'd1 << m_addr[12:6]) : 128'd0);
      chk("R2", {64'b0, y_drive}, drv ? (128'd1 << m_addr[5:0]) : 128'd0);
      if (ph != 2) chk("R7", {110'b0, inhibit}, 128'd0);
      else if (m_known || (m_mode && m_be == 2'b11))
        chk("R7", {110'b0, inhibit}, {110'b0, ~m_target()});
      if (ph == 3 && m_known) chk(cur_tag, {110'b0, rsp_data}, {110'b0, m_sensed});
    end
  end

  task automatic op(input logic m, input logic [12:0] ad, input logic [1:0] b,
                    input logic [17:0] d, input bit hold, input string tag);
    cur_tag = tag;
    req_mode = m; req_addr = ad; req_be = b; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    if (hold) begin
      // R9: a second request while busy must be ignored
      req_addr = ad ^ 13'h155; req_mode = 1'b1; req_wdata = ~d; req_be = 2'b11;
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {127'b0, req_ready}, 128'd1);
    chk("R10", {127'b0, busy}, 128'd0);
    chk("R10", {127'b0, done}, 128'd0);
    chk("R10", {127'b0, drive_en | sense_strobe}, 128'd0);
    chk("R10", {110'b0, inhibit}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    op(1'b1, 13'h0000, 2'b11, 18'h2AAAA, 0, "R8");
    op(1'b0, 13'h0000, 2'b11, 18'h00000, 0, "R5");
    op(1'b0, 13'h0000, 2'b00, 18'h3FFFF, 0, "R4");
    op(1'b1, 13'h1FFF, 2'b11, 18'h3FFFF, 0, "R8");
    op(1'b0, 13'h1FFF, 2'b11, 18'h00000, 0, "R5");
    op(1'b1, 13'h1234, 2'b11, 18'h00000, 0, "R8");
    op(1'b0, 13'h1234, 2'b01, 18'h15555, 0, "R5");
    op(1'b1, 13'h0000, 2'b01, 18'h00000, 0, "R6");
    op(1'b0, 13'h0000, 2'b11, 18'h00000, 0, "R6");
    op(1'b1, 13'h0000, 2'b10, 18'h3FFFF, 0, "R6");
    op(1'b0, 13'h0000, 2'b10, 18'h00000, 0, "R6");
    op(1'b0, 13'h0000, 2'b00, 18'h00000, 0, "R6");
    op(1'b1, 13'h0A5C, 2'b11, 18'h12345, 1, "R8");
    op(1'b0, 13'h0A5C, 2'b11, 18'h00000, 1, "R9");
    op(1'b0, 13'h0A5C, 2'b11, 18'h00000, 0, "R4");
    op(1'b1, 13'h0A5C, 2'b11, 18'h0F0F0, 0, "R8");
    op(1'b0, 13'h0A5C, 2'b11, 18'h00000, 0, "R5");
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule